// File: doc/BRIEF.md
# Wormhole Router Input Port with Per-Class Buffering

This block is one input port of a mesh network-on-chip router that uses wormhole switching. Flits arrive from the upstream router on a single flit bus. Each flit carries a kind field and a service class field. Flits that are not idle are written into a FIFO, and the service class picks which FIFO. There is one FIFO for each class. For every class the port offers the flit at the head of its FIFO to the crossbar, along with the output direction that flit must take. When the crossbar pops a flit, the port returns one credit pulse for that class to the upstream router.

Each class keeps its own route entry. When a first flit is at the head of its FIFO, its direction comes from dimension-ordered XY routing. The target X and Y coordinates in its payload are compared with this router's coordinates. Popping that first flit stores the direction in the route entry for its class. The body flits and the end flit of the same packet then use the stored direction. Popping the end flit releases the entry. A first flit can be marked as a single-flit packet: it is routed and released in the same transfer and never holds the entry.

Top module: `wh_input_port`

Flit layout (FLIT_W = 2 + log2(NUM_SL) + PAYLOAD_W):

| Field | Bits |
|---|---|
| Kind | top two bits |
| Service class | the next log2(NUM_SL) bits |
| Payload | the remaining bits |

First-flit payload layout:

| Field | Bits |
|---|---|
| Target X | bits [COORD_W-1:0] |
| Target Y | bits [2*COORD_W-1:COORD_W] |
| Single-flit mark | bit [2*COORD_W] |

## Requirements
- R1: While reset is held, and after it is released, `head_valid`, `credit` and `route_busy` are all zero until a flit arrives.
- R2: A flit whose kind is First (1), Body (2) or End (3) is stored in the FIFO of the class in its service-class field. Each class gives its flits back in arrival order, and the flit becomes visible at the head one cycle after it is presented.
- R3: A flit of kind Idle (0) is never stored, whatever its class field holds.
- R4: Each class FIFO holds DEPTH flits (4 by default). A write into a full FIFO is illegal and is flagged.
- R5: While a class holds a flit and is not popped, `head_valid` for that class stays high and its head flit does not change.
- R6: In a cycle where `pop` and `head_valid` are both high for a class, `credit` for that class is high in the same cycle. Otherwise `credit` for that class is low.
- R7: The direction codes are Local=0, North=1, South=2, East=3 and West=4. For a First flit at the head, the direction is chosen as follows:
  - East if the target X is greater than `here_x`.
  - West if the target X is less than `here_x`.
  - Otherwise North if the target Y is greater than `here_y`.
  - Otherwise South if the target Y is less than `here_y`.
  - Otherwise Local.
- R8: Popping a First flit without the single-flit mark sets `route_busy` for its class and stores its direction. Body and End flits at the head of that class show the stored direction, even if `here_x` or `here_y` change afterwards.
- R9: Popping an End flit clears `route_busy`. Popping a First flit with the single-flit mark leaves `route_busy` low.
- R10: Classes are independent. Packets of different classes that are interleaved at the input keep their own routes.
- R11: A pop on a class with an empty FIFO is ignored: no credit is issued and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| here_x | input | COORD_W | X coordinate of this router |
| here_y | input | COORD_W | Y coordinate of this router |
| in_flit | input | FLIT_W | Flit from the upstream router |
| pop | input | NUM_SL | Crossbar takes the head flit of each class |
| head_valid | output | NUM_SL | The class FIFO holds a flit |
| head_flit | output | NUM_SL*FLIT_W | Head flit of each class, class 0 in the low bits |
| head_dir | output | NUM_SL*3 | Requested output direction of each class |
| route_busy | output | NUM_SL | A packet's route is held for the class |
| credit | output | NUM_SL | One-cycle credit pulse for each class returned upstream |

## Verification
The assertions assume that the upstream router obeys its credits, so it never writes into a full class FIFO. They also assume that it does not start a new packet on a class whose route is still held: a First flit never reaches a head while `route_busy` is set. The stimulus keeps within both assumptions. Each class is filled to at most DEPTH flits before it is drained, and every packet on a class is finished with an End flit, or marked single-flit, before another First flit is sent on that class. The crossbar side may pop an empty class, and the bench does so on purpose.

// File: rtl/wh_input_port_pkg.sv
`timescale 1ns/1ps
package wh_input_port_pkg;
  typedef enum logic [1:0] {
    FK_IDLE  = 2'd0,
    FK_FIRST = 2'd1,
    FK_BODY  = 2'd2,
    FK_END   = 2'd3
  } flit_kind_t;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_SOUTH = 3'd2,
    DIR_EAST  = 3'd3,
    DIR_WEST  = 3'd4
  } out_dir_t;
endpackage

// File: rtl/wh_rst_sync.sv
`timescale 1ns/1ps
module wh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/wh_class_fifo.sv
`timescale 1ns/1ps
module wh_class_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_wr) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_rd) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data;
  end

  // R4: upstream must respect credits
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full));

  // R5: an unpopped head stays put
  assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_en) |=> (!empty && $stable(rd_data)));
endmodule

// File: rtl/wh_xy_route.sv
`timescale 1ns/1ps
module wh_xy_route
  import wh_input_port_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  output out_dir_t           dir
);
  always_comb begin
    if (dst_x > here_x)      dir = DIR_EAST;
    else if (dst_x < here_x) dir = DIR_WEST;
    else if (dst_y > here_y) dir = DIR_NORTH;
    else if (dst_y < here_y) dir = DIR_SOUTH;
    else                     dir = DIR_LOCAL;
  end
endmodule

// File: rtl/wh_class_lane.sv
`timescale 1ns/1ps
module wh_class_lane
  import wh_input_port_pkg::*;
#(
  parameter int FLIT_W  = 20,
  parameter int COORD_W = 4,
  parameter int DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLIT_W-1:0] wr_flit,
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  input  logic              pop,
  output logic              head_valid,
  output logic [FLIT_W-1:0] head_flit,
  output logic [2:0]        head_dir,
  output logic              busy,
  output logic              credit
);
  logic       empty, full, take, solo;
  flit_kind_t hk;
  out_dir_t   calc_dir;
  logic [2:0] dir_q, dir_d;
  logic       busy_q, busy_d;

  wh_class_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_flit),
    .rd_en(pop), .rd_data(head_flit), .empty(empty), .full(full)
  );

  wh_xy_route #(.COORD_W(COORD_W)) u_route (
    .dst_x(head_flit[COORD_W-1:0]),
    .dst_y(head_flit[2*COORD_W-1:COORD_W]),
    .here_x(here_x), .here_y(here_y), .dir(calc_dir)
  );

  assign hk         = flit_kind_t'(head_flit[FLIT_W-1 -: 2]);
  assign solo       = head_flit[2*COORD_W];
  assign head_valid = !empty;
  assign take       = pop && !empty;
  assign credit     = take;
  assign busy       = busy_q;
  assign head_dir   = (hk == FK_FIRST) ? 3'(calc_dir) : dir_q;

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    if (take) begin
      case (hk)
        FK_FIRST: if (!solo) begin
          busy_d = 1'b1;
          dir_d  = 3'(calc_dir);
        end
        FK_END:   busy_d = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 3'd0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
    end
  end

  // R8: wormhole ordering - a new packet only starts on a free class
  assert_first_on_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && hk == FK_FIRST) |-> !busy);

  // R8: body transfers keep the held route
  assert_body_keeps_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (credit && hk == FK_BODY) |=> (busy && $stable(dir_q)));

  // R9: end transfer releases the route
  assert_end_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (credit && hk == FK_END) |=> !busy);

  // R11: no credit from an empty class
  assert_no_empty_credit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !head_valid) |=> $stable(busy));
endmodule

// File: rtl/wh_input_port.sv
`timescale 1ns/1ps
module wh_input_port
  import wh_input_port_pkg::*;
#(
  parameter int NUM_SL    = 4,
  parameter int PAYLOAD_W = 16,
  parameter int COORD_W   = 4,
  parameter int DEPTH     = 4,
  parameter int FLIT_W    = 2 + $clog2(NUM_SL) + PAYLOAD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COORD_W-1:0]       here_x,
  input  logic [COORD_W-1:0]       here_y,
  input  logic [FLIT_W-1:0]        in_flit,
  input  logic [NUM_SL-1:0]        pop,
  output logic [NUM_SL-1:0]        head_valid,
  output logic [NUM_SL*FLIT_W-1:0] head_flit,
  output logic [NUM_SL*3-1:0]      head_dir,
  output logic [NUM_SL-1:0]        route_busy,
  output logic [NUM_SL-1:0]        credit
);
  localparam int SL_W = $clog2(NUM_SL);

  logic            rst_n_i;
  flit_kind_t      in_kind;
  logic [SL_W-1:0] in_sl;

  assign in_kind = flit_kind_t'(in_flit[FLIT_W-1 -: 2]);
  assign in_sl   = in_flit[FLIT_W-3 -: SL_W];

  wh_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  for (genvar l = 0; l < NUM_SL; l++) begin : g_lane
    logic wr_en_l;
    assign wr_en_l = (in_kind != FK_IDLE) && (in_sl == SL_W'(l));

    wh_class_lane #(.FLIT_W(FLIT_W), .COORD_W(COORD_W), .DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en_l), .wr_flit(in_flit),
      .here_x(here_x), .here_y(here_y), .pop(pop[l]),
      .head_valid(head_valid[l]),
      .head_flit(head_flit[l*FLIT_W +: FLIT_W]),
      .head_dir(head_dir[l*3 +: 3]),
      .busy(route_busy[l]), .credit(credit[l])
    );

    // R2 / R3: a class only fills from a non-idle flit addressed to it
    assert_fill_source_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
      $rose(head_valid[l]) |->
        ($past(in_flit[FLIT_W-1 -: 2]) != 2'd0 &&
         $past(in_flit[FLIT_W-3 -: SL_W]) == SL_W'(l)));
  end
endmodule

// File: tb/wh_input_port_test.sv
`timescale 1ns/1ps
module wh_input_port_test;
  localparam int NSL = 4, PW = 16, CW = 4, DEPTH = 4;
  localparam int FW = 2 + 2 + PW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CW-1:0]     here_x, here_y;
  logic [FW-1:0]     in_flit;
  logic [NSL-1:0]    pop;
  logic [NSL-1:0]    head_valid, route_busy, credit;
  logic [NSL*FW-1:0] head_flit;
  logic [NSL*3-1:0]  head_dir;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wh_input_port #(.NUM_SL(NSL), .PAYLOAD_W(PW), .COORD_W(CW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
    .in_flit(in_flit), .pop(pop), .head_valid(head_valid),
    .head_flit(head_flit), .head_dir(head_dir),
    .route_busy(route_busy), .credit(credit)
  );

  function automatic logic [FW-1:0] mk(input int kind, input int sl, input logic [PW-1:0] pl);
    return {2'(kind), 2'(sl), pl};
  endfunction

  function automatic logic [PW-1:0] addr(input int dx, input int dy, input bit solo);
    return PW'({solo, 4'(dy), 4'(dx)});
  endfunction

  function automatic int xy(input int dx, input int dy, input int hx, input int hy);
    if (dx > hx) return 3;
    if (dx < hx) return 4;
    if (dy > hy) return 1;
    if (dy < hy) return 2;
    return 0;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [FW-1:0] f);
    in_flit = f;
    tick();
    in_flit = '0;
  endtask

  task automatic take(input int l, input string req);
    pop[l] = 1'b1;
    #1;
    check(req, credit, 64'(1) << l);
    tick();
    pop = '0;
  endtask

  function automatic int dir_of(input int l);
    return int'(head_dir[l*3 +: 3]);
  endfunction

  function automatic logic [FW-1:0] flit_of(input int l);
    return head_flit[l*FW +: FW];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pop = '0; in_flit = '0; here_x = '0; here_y = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", head_valid, 0);
    check("R1 busy in reset", route_busy, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 valid after reset", head_valid, 0);
    check("R1 credit after reset", credit, 0);
    check("R1 busy after reset", route_busy, 0);

    // R7 / R9: route sweep with single-flit packets
    for (int hx = 0; hx < 4; hx++)
      for (int hy = 0; hy < 4; hy++) begin
        here_x = CW'(hx); here_y = CW'(hy);
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 4; dy++) begin
            int l;
            logic [FW-1:0] f;
            l = (dx + dy + hx) % 4;
            f = mk(1, l, addr(dx, dy, 1'b1));
            push(f);
            check("R2 valid", head_valid, 64'(1) << l);
            check("R2 head flit", flit_of(l), f);
            check("R7 direction", dir_of(l), xy(dx, dy, hx, hy));
            take(l, "R6 credit");
            check("R9 solo leaves free", route_busy, 0);
            check("R2 drained", head_valid, 0);
          end
      end

    // R3: idle flits dropped on every class
    for (int l = 0; l < NSL; l++) begin
      push(mk(0, l, 16'hBEEF));
      check("R3 idle dropped", head_valid, 0);
    end

    // R11: pop on empty class
    pop[2] = 1'b1;
    #1;
    check("R11 no credit", credit, 0);
    tick();
    pop = '0;
    check("R11 state unchanged", {head_valid, route_busy}, 0);

    // R4 / R5 / R8 / R9: fill class 1 to depth, route held across coordinate change
    here_x = 4'd1; here_y = 4'd1;
    begin
      logic [FW-1:0] pk [DEPTH];
      pk[0] = mk(1, 1, addr(3, 0, 1'b0));
      for (int i = 1; i < DEPTH; i++) pk[i] = mk(2, 1, PW'(16'h1000 + i));
      for (int i = 0; i < DEPTH; i++) push(pk[i]);
      tick();
      check("R5 head held", flit_of(1), pk[0]);
      check("R7 first east", dir_of(1), 3);
      take(1, "R6 credit first");
      check("R8 busy set", route_busy, 4'b0010);
      here_x = 4'd3; here_y = 4'd0;
      for (int i = 1; i < DEPTH; i++) begin
        check("R4 order kept", flit_of(1), pk[i]);
        check("R8 body uses held dir", dir_of(1), 3);
        take(1, "R6 credit body");
        check("R8 busy held", route_busy, 4'b0010);
      end
      push(mk(3, 1, 16'h00EE));
      check("R8 end uses held dir", dir_of(1), 3);
      take(1, "R6 credit end");
      check("R9 end releases", route_busy, 0);
      check("R4 drained", head_valid, 0);
    end

    // R10: interleaved packets on classes 0 and 3
    here_x = 4'd2; here_y = 4'd1;
    push(mk(1, 0, addr(0, 1, 1'b0)));
    push(mk(1, 3, addr(2, 3, 1'b0)));
    push(mk(2, 0, 16'h0A0A));
    push(mk(3, 3, 16'h0B0B));
    push(mk(3, 0, 16'h0C0C));
    check("R10 both valid", head_valid, 4'b1001);
    check("R10 class0 west", dir_of(0), 4);
    check("R10 class3 north", dir_of(3), 1);
    take(0, "R10 credit c0");
    take(3, "R10 credit c3");
    check("R10 both busy", route_busy, 4'b1001);
    here_y = 4'd3;
    check("R10 class0 body west", dir_of(0), 4);
    check("R10 class3 end north", dir_of(3), 1);
    take(3, "R10 credit c3 end");
    check("R10 only c3 freed", route_busy, 4'b0001);
    take(0, "R10 credit c0 body");
    check("R10 c0 end west", dir_of(0), 4);
    take(0, "R10 credit c0 end");
    check("R10 all free", route_busy, 0);
    check("R10 all empty", head_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule